// File: doc/BRIEF.md
# Acknowledge Polling Write Sequencer

This controller-side sequencer runs one operation against a serial EEPROM that may still be busy with an internal programming cycle. A busy memory answers its slave address with no acknowledge. The sequencer therefore keeps opening the bus with a START and sending the address byte until the memory pulls the acknowledge low. The polling address byte is also the address phase of the real command, so its R/W bit already matches the operation that follows. Once the acknowledge arrives, the sequencer carries straight on with the transfer and issues no further START.

The sequencer does not handle SCL or SDA timing. It drives a byte-level bus engine with one command at a time: START, write byte, read byte or STOP. It waits for the engine's response pulse, which carries the sampled acknowledge bit or the byte read. A write-type request sends the word address and one data byte and then STOP. A current-read request reads one byte, answers it with a high (not-acknowledge) bit and then STOP. A cycle counter bounds how long polling may last. When the bound is reached, the sequencer closes the bus and reports a timeout instead of completion.

Top module: `ack_poll_seq`

## Requirements
- R1: After reset the sequencer is idle: busy, done and timeout are low and no engine command is issued while idle.
- R2: Every poll attempt is a START command followed by one write command carrying the address byte, which has the 7-bit device address in bits 7:1 and the R/W flag in bit 0. The flag is 0 for a write request and 1 for a current-read request.
- R3: When the address byte returns a high acknowledge and the polling bound has not been reached, the next command is a new START and the address byte is sent again.
- R4: After a low address acknowledge on a write request, the next commands are the word-address byte, then the data byte, then STOP, with no START in between. done pulses one cycle after the STOP response.
- R5: After a low address acknowledge on a current-read request, exactly one read command is issued with its not-acknowledge flag set to 1, followed by STOP. done pulses together with rd_data holding the byte returned by the engine.
- R6: The polling bound is POLL_LIMIT clock cycles counted from request acceptance. A high address acknowledge received at or after the bound causes STOP without any data transfer, and then a timeout pulse without done.
- R7: cmd_valid is a one-cycle pulse, and no new command is issued until the engine has answered the previous one with rsp_valid.
- R8: A request raised while busy is ignored and changes neither the running transaction nor any later one.
- R9: busy is high from the cycle after request acceptance until the final STOP response. done and timeout are single-cycle pulses, never high together, and appear only while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start one operation (accepted when idle) |
| req_read | input | 1 | 1 = current read, 0 = byte write |
| dev_addr | input | 7 | Device address sent in the address byte |
| word_addr | input | 8 | Word address for a write |
| wr_data | input | 8 | Data byte for a write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Pulse: operation completed |
| timeout | output | 1 | Pulse: polling bound reached, operation abandoned |
| rd_data | output | 8 | Byte returned by the last current read |
| cmd_valid | output | 1 | Pulse: issue a command to the bus engine |
| cmd_op | output | 2 | Command: 0 START, 1 write byte, 2 read byte, 3 STOP |
| cmd_data | output | 8 | Byte to write |
| cmd_nack | output | 1 | Acknowledge bit to return after a read byte |
| rsp_valid | input | 1 | Pulse: engine finished the outstanding command |
| rsp_ack | input | 1 | Sampled acknowledge bit of a written byte (0 = acknowledged) |
| rsp_data | input | 8 | Byte received by a read command |

## Verification
A wrong state register shows up at the command port within one engine round trip. The symptoms are a START placed after an acknowledged address, a data byte sent while the memory is still refusing its address, or an address byte with the wrong R/W bit. A polling timer that is too short or never expires shows as a timeout that comes early or never comes, and the timeout time is compared against the bound in cycles. A lost read capture or a swapped completion flag is visible on rd_data, done and timeout in the cycle after the closing STOP response.

// File: rtl/apw_pkg.sv
package apw_pkg;
    localparam int DEV_W  = 7;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        BUS_START = 2'd0,
        BUS_WRITE = 2'd1,
        BUS_READ  = 2'd2,
        BUS_STOP  = 2'd3
    } bus_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_ADDR,
        ST_WORD,
        ST_DATA,
        ST_READ,
        ST_STOP
    } seq_state_e;

    typedef struct packed {
        seq_state_e        st;
        logic              pend;
        logic              rd;
        logic              fail;
        logic [DEV_W-1:0]  dev;
        logic [BYTE_W-1:0] wa;
        logic [BYTE_W-1:0] wd;
    } seq_regs_t;

    typedef struct packed {
        logic              done;
        logic              tmo;
        logic [BYTE_W-1:0] rdat;
    } res_regs_t;
endpackage

// File: rtl/apw_poll_timer.sv
module apw_poll_timer #(
    parameter int LIMIT = 600000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (run && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == CNT_MAX);
endmodule

// File: rtl/apw_fsm.sv
module apw_fsm
    import apw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_read,
    input  logic [DEV_W-1:0]  dev_addr,
    input  logic [BYTE_W-1:0] word_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rsp_valid,
    input  logic              rsp_ack,
    input  logic              expired,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [BYTE_W-1:0] cmd_data,
    output logic              cmd_nack,
    output logic              busy,
    output logic              poll_active,
    output logic              timer_clear,
    output logic              fin_ok,
    output logic              fin_tmo,
    output logic              rd_take
);
    seq_regs_t q, d;
    bus_op_e   op;
    logic      issue;
    logic      got;

    always_comb begin
        d           = q;
        op          = BUS_START;
        cmd_data    = '0;
        cmd_nack    = 1'b0;
        timer_clear = 1'b0;
        fin_ok      = 1'b0;
        fin_tmo     = 1'b0;
        rd_take     = 1'b0;
        issue       = (q.st != ST_IDLE) && !q.pend;
        got         = q.pend && rsp_valid;

        case (q.st)
            ST_IDLE: begin
                if (req) begin
                    d.st        = ST_START;
                    d.rd        = req_read;
                    d.dev       = dev_addr;
                    d.wa        = word_addr;
                    d.wd        = wr_data;
                    d.fail      = 1'b0;
                    timer_clear = 1'b1;
                end
            end
            ST_START: begin
                op = BUS_START;
                if (got) d.st = ST_ADDR;
            end
            ST_ADDR: begin
                op       = BUS_WRITE;
                cmd_data = {q.dev, q.rd};
                if (got) begin
                    if (!rsp_ack) begin
                        d.st = q.rd ? ST_READ : ST_WORD;
                    end else if (expired) begin
                        d.st   = ST_STOP;
                        d.fail = 1'b1;
                    end else begin
                        d.st = ST_START;
                    end
                end
            end
            ST_WORD: begin
                op       = BUS_WRITE;
                cmd_data = q.wa;
                if (got) d.st = ST_DATA;
            end
            ST_DATA: begin
                op       = BUS_WRITE;
                cmd_data = q.wd;
                if (got) d.st = ST_STOP;
            end
            ST_READ: begin
                op       = BUS_READ;
                cmd_nack = 1'b1;
                if (got) begin
                    rd_take = 1'b1;
                    d.st    = ST_STOP;
                end
            end
            ST_STOP: begin
                op = BUS_STOP;
                if (got) begin
                    d.st    = ST_IDLE;
                    fin_ok  = !q.fail;
                    fin_tmo = q.fail;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (issue) begin
            d.pend = 1'b1;
        end else if (got) begin
            d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, pend: 1'b0, rd: 1'b0, fail: 1'b0,
                   dev: '0, wa: '0, wd: '0};
        end else begin
            q <= d;
        end
    end

    assign cmd_valid   = issue;
    assign cmd_op      = op;
    assign busy        = (q.st != ST_IDLE);
    assign poll_active = (q.st == ST_START) || (q.st == ST_ADDR);
endmodule

// File: rtl/apw_result.sv
module apw_result
    import apw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fin_ok,
    input  logic              fin_tmo,
    input  logic              rd_take,
    input  logic [BYTE_W-1:0] rsp_data,
    output logic              done,
    output logic              timeout,
    output logic [BYTE_W-1:0] rd_data
);
    res_regs_t q, d;

    always_comb begin
        d      = q;
        d.done = fin_ok;
        d.tmo  = fin_tmo;
        if (rd_take) d.rdat = rsp_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{done: 1'b0, tmo: 1'b0, rdat: '0};
        end else begin
            q <= d;
        end
    end

    assign done    = q.done;
    assign timeout = q.tmo;
    assign rd_data = q.rdat;
endmodule

// File: rtl/ack_poll_seq.sv
module ack_poll_seq
    import apw_pkg::*;
#(
    parameter int POLL_LIMIT = 600000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_read,
    input  logic [DEV_W-1:0]  dev_addr,
    input  logic [BYTE_W-1:0] word_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              busy,
    output logic              done,
    output logic              timeout,
    output logic [BYTE_W-1:0] rd_data,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [BYTE_W-1:0] cmd_data,
    output logic              cmd_nack,
    input  logic              rsp_valid,
    input  logic              rsp_ack,
    input  logic [BYTE_W-1:0] rsp_data
);
    logic expired;
    logic poll_active;
    logic timer_clear;
    logic fin_ok;
    logic fin_tmo;
    logic rd_take;

    apw_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (timer_clear),
        .run     (poll_active),
        .expired (expired)
    );

    apw_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .req_read    (req_read),
        .dev_addr    (dev_addr),
        .word_addr   (word_addr),
        .wr_data     (wr_data),
        .rsp_valid   (rsp_valid),
        .rsp_ack     (rsp_ack),
        .expired     (expired),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_data    (cmd_data),
        .cmd_nack    (cmd_nack),
        .busy        (busy),
        .poll_active (poll_active),
        .timer_clear (timer_clear),
        .fin_ok      (fin_ok),
        .fin_tmo     (fin_tmo),
        .rd_take     (rd_take)
    );

    apw_result u_result (
        .clk      (clk),
        .rst_n    (rst_n),
        .fin_ok   (fin_ok),
        .fin_tmo  (fin_tmo),
        .rd_take  (rd_take),
        .rsp_data (rsp_data),
        .done     (done),
        .timeout  (timeout),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/apw_checker.sv
module apw_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       timeout,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic       cmd_nack
);
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cmd_valid); // R1

    AST_SINGLE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid); // R7

    AST_READ_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd2) |-> cmd_nack); // R5

    AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout)); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_TMO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout); // R6

    AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done || timeout) |-> !busy); // R9
endmodule

bind ack_poll_seq apw_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .timeout   (timeout),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_nack  (cmd_nack)
);

// File: tb/sim_ack_poll_seq.sv
module sim_ack_poll_seq;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 300;
    localparam int WCYC       = 40;
    localparam int LAT        = 2;
    localparam logic [6:0] DEV = 7'b1010011;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic       req_read = 1'b0;
    logic [6:0] dev_addr = DEV;
    logic [7:0] word_addr = '0;
    logic [7:0] wr_data = '0;
    logic       busy, done, timeout;
    logic [7:0] rd_data;
    logic       cmd_valid;
    logic [1:0] cmd_op;
    logic [7:0] cmd_data;
    logic       cmd_nack;
    logic       rsp_valid = 1'b0;
    logic       rsp_ack = 1'b0;
    logic [7:0] rsp_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ack_poll_seq #(.POLL_LIMIT(LIMIT)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .req_read(req_read),
        .dev_addr(dev_addr), .word_addr(word_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .timeout(timeout), .rd_data(rd_data),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .cmd_nack(cmd_nack), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack),
        .rsp_data(rsp_data)
    );

    int checks = 0;
    int errors = 0;

    // memory device model behind the byte engine
    logic [7:0] mem [256];
    int   wbusy = 0;
    bit   stuck = 1'b0;
    bit   sel = 1'b0, rw = 1'b0, last_acked = 1'b0, pend_v = 1'b0;
    int   idx = 0, lat = 0;
    logic [7:0] ptr = '0, pend_d = '0, r_data = '0;
    bit   r_ack = 1'b0;
    bit   exp_rw = 1'b0;
    int   n_start, n_addr, n_rw_bad, n_data, n_read, n_stop, n_ack_start, n_nack_bad;

    // op results
    bit   got_done, got_tmo;
    logic [7:0] got_rd;
    int   cyc;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
        forever begin
            @(negedge clk);
            rsp_valid = 1'b0;
            if (wbusy > 0) wbusy--;
            if (lat > 0) begin
                lat--;
                if (lat == 0) begin
                    rsp_valid = 1'b1;
                    rsp_ack   = r_ack;
                    rsp_data  = r_data;
                end
            end else if (cmd_valid) begin
                lat = LAT;
                r_ack = 1'b0;
                case (cmd_op)
                    2'd0: begin
                        n_start++;
                        if (last_acked) n_ack_start++;
                        idx = 0; sel = 1'b0;
                    end
                    2'd1: begin
                        if (idx == 0) begin
                            n_addr++;
                            if (cmd_data[0] !== exp_rw) n_rw_bad++;
                            sel = (cmd_data[7:1] == DEV) && (wbusy == 0) && !stuck;
                            rw  = cmd_data[0];
                            r_ack = !sel;
                            last_acked = sel;
                        end else if (sel && !rw) begin
                            n_data++;
                            if (idx == 1) ptr = cmd_data;
                            else begin pend_d = cmd_data; pend_v = 1'b1; end
                        end else begin
                            r_ack = 1'b1;
                        end
                        idx++;
                    end
                    2'd2: begin
                        n_read++;
                        if (!cmd_nack) n_nack_bad++;
                        r_data = mem[ptr];
                        ptr = ptr + 8'd1;
                        r_ack = cmd_nack;
                    end
                    default: begin
                        n_stop++;
                        if (pend_v) begin
                            mem[ptr] = pend_d;
                            wbusy = WCYC;
                            pend_v = 1'b0;
                        end
                        sel = 1'b0; last_acked = 1'b0;
                    end
                endcase
            end
        end
    end

    task automatic start_op(input bit rd, input logic [7:0] wa, input logic [7:0] wd);
        n_start = 0; n_addr = 0; n_rw_bad = 0; n_data = 0; n_read = 0;
        n_stop = 0; n_ack_start = 0; n_nack_bad = 0;
        exp_rw = rd;
        @(negedge clk);
        req = 1'b1; req_read = rd; word_addr = wa; wr_data = wd;
        @(negedge clk);
        req = 1'b0;
        cyc = 1;
    endtask

    task automatic wait_end();
        got_done = 1'b0; got_tmo = 1'b0;
        while (!(done || timeout) && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        got_done = done; got_tmo = timeout; got_rd = rd_data;
        check(cyc < 5000, "R9 operation ends", cyc, 5000);
    endtask

    typedef struct packed {
        logic       rd;
        logic [7:0] wa;
        logic [7:0] wd;
        logic [7:0] exp;
        logic       multi;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{1'b0, 8'h10, 8'hA5, 8'h00, 1'b0},
        '{1'b1, 8'h00, 8'h00, 8'hA5, 1'b1},
        '{1'b0, 8'h3C, 8'h5A, 8'h00, 1'b0},
        '{1'b0, 8'h3D, 8'hC3, 8'h00, 1'b1},
        '{1'b1, 8'h00, 8'h00, 8'hC3, 1'b1},
        '{1'b1, 8'h00, 8'h00, 8'hFF, 1'b0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during and after reset
        check(!busy && !done && !timeout && !cmd_valid, "R1 in reset", busy, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy && !done && !timeout && !cmd_valid, "R1 after reset", cmd_valid, 0);

        foreach (VEC[i]) begin
            start_op(VEC[i].rd, VEC[i].wa, VEC[i].wd);
            check(busy, "R9 busy after accept", busy, 1);
            wait_end();
            check(got_done && !got_tmo, "R4/R5 done without timeout", got_tmo, 0);
            check(n_rw_bad == 0, "R2 R/W bit of address byte", n_rw_bad, 0);
            check(n_start == n_addr, "R2 one address per START", n_addr, n_start);
            check(n_ack_start == 0, "R4 no START after acknowledge", n_ack_start, 0);
            if (VEC[i].multi) check(n_addr >= 2, "R3 retried while busy", n_addr, 2);
            else              check(n_addr == 1, "R3 single attempt when ready", n_addr, 1);
            check(n_stop == 1, "R4/R5 single STOP", n_stop, 1);
            if (VEC[i].rd) begin
                check(got_rd == VEC[i].exp, "R5 read data", got_rd, VEC[i].exp);
                check(n_read == 1 && n_data == 0, "R5 one read byte", n_read, 1);
                check(n_nack_bad == 0, "R5 read ends with high ack", n_nack_bad, 0);
            end else begin
                check(n_data == 2 && n_read == 0, "R4 word address and data", n_data, 2);
            end
            @(negedge clk);
            check(!done && !busy, "R9 done is one pulse", done, 0);
        end

        // R6: memory never acknowledges
        stuck = 1'b1;
        start_op(1'b0, 8'h20, 8'h77);
        wait_end();
        check(got_tmo && !got_done, "R6 timeout raised", got_tmo, 1);
        check(cyc >= LIMIT && cyc <= LIMIT + 40, "R6 timeout timing", cyc, LIMIT);
        check(n_data == 0 && n_stop == 1, "R6 STOP without data", n_data, 0);
        check(n_addr > 2 && n_start == n_addr, "R3 repeated polling", n_addr, n_start);
        stuck = 1'b0;
        @(negedge clk);
        check(!timeout && !busy, "R6 timeout is one pulse", timeout, 0);

        // R6: wrong device address never answered
        dev_addr = 7'b1010000;
        exp_rw = 1'b1;
        start_op(1'b1, 8'h00, 8'h00);
        wait_end();
        check(got_tmo && !got_done && n_read == 0, "R6 mismatched device", got_tmo, 1);
        dev_addr = DEV;

        // R8: request while busy is ignored
        start_op(1'b0, 8'h50, 8'h11);
        req = 1'b1; word_addr = 8'h51; wr_data = 8'h22;
        @(negedge clk);
        req = 1'b0;
        cyc++;
        wait_end();
        check(got_done && n_stop == 1 && n_data == 2, "R8 single transaction", n_stop, 1);
        repeat (4) @(negedge clk);
        check(!busy, "R8 no second operation started", busy, 0);
        start_op(1'b1, 8'h00, 8'h00);
        wait_end();
        check(got_rd == 8'h11, "R8 first write kept", got_rd, 8'h11);
        start_op(1'b1, 8'h00, 8'h00);
        wait_end();
        check(got_rd == 8'hFF, "R8 ignored write absent", got_rd, 8'hFF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule